// File: doc/BRIEF.md
# Dual-Source Watchdog with Interval Prescaler

This block guards a small 8-bit controller against a runaway program. A prescaler divides the main clock by one of eight power-of-two ratios and feeds an 8-bit interval counter. When that counter wraps, it raises an interval flag. A 7-bit watchdog counter advances on each wrap of the interval counter, or on every 256th rising edge of an independent slow oscillator input. Because the slow oscillator keeps running when stop mode freezes the main-clock path, the watchdog still counts during stop.

When the watchdog count reaches a limit that software programs, the counter restarts from zero. A mode bit then decides what the match does: it either pulses a CPU reset or sets a sticky watchdog interrupt flag. Software keeps the watchdog from firing by writing a self-clearing clear bit. In reset mode the watchdog stays idle until software arms it by clearing the interval counter with the mode bit set.

Two byte-wide registers are reached through one write/read port:
- Control register (select 0): bit 6 is a spare wake bit, bit 5 enables the oscillator source, bit 4 is the reset mode bit, bit 3 is the interval clear bit and bits 2:0 are the prescale select.
- Watchdog register (select 1): bit 7 is the clear bit and bits 6:0 are the limit.

Top module: `wdog_dual_src`

## Requirements
- R1: After reset the control register reads 0x17 (bit 7 and bit 3 read 0, wake=0, oscillator enable=0, reset mode=1, select=7). The watchdog register reads 0x7F, and all three outputs are low.
- R2: Select code n makes the interval counter advance every 2^(n+3) main-clock cycles, so it wraps every 256·2^(n+3) cycles. Each wrap sets ivl_irq_o, which stays high until flag_clr_i[0] is pulsed.
- R3: Writing the control register with bit 3 set zeroes the prescaler and the interval counter. Bit 3 always reads back 0.
- R4: While stop_i is high, the prescaler and the interval counter hold their values and no wrap occurs.
- R5: With oscillator enable at 0, each interval wrap advances the watchdog counter. A match occurs when the advanced value equals the limit, so a match comes every limit-many wraps, and the counter then returns to 0.
- R6: With oscillator enable at 1, the watchdog counter advances once per 256 rising edges of osc_i, and it keeps doing so while stop_i is high.
- R7: Writing the watchdog register with bit 7 set zeroes the watchdog counter. Bit 7 reads 1 until the next clock edge and 0 after it.
- R8: In reset mode (bit 4 = 1), a match drives cpu_rst_o high for exactly one cycle, in the cycle right after the matching tick edge.
- R9: In interrupt mode (bit 4 = 0), a match sets wdt_irq_o, which stays high until flag_clr_i[1] is pulsed. No reset is produced.
- R10: In reset mode the watchdog counter does not advance until a control write with bits 4 and 3 both set. A control write with bit 4 cleared disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 watchdog |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control, 1 watchdog |
| rd_data_o | output | 8 | Read data (combinational) |
| stop_i | input | 1 | Stop mode, freezes the main-clock path |
| osc_i | input | 1 | Slow oscillator level, asynchronous |
| flag_clr_i | input | 2 | Bit 0 clears ivl_irq_o, bit 1 clears wdt_irq_o |
| ivl_irq_o | output | 1 | Interval wrap flag |
| wdt_irq_o | output | 1 | Watchdog interrupt flag |
| cpu_rst_o | output | 1 | One-cycle CPU reset pulse |

## Verification
The assertions check on every cycle that:
- a reset pulse lasts one cycle and appears only while reset mode was set;
- both flags hold until their clear bit;
- the watchdog flag rises only in interrupt mode;
- stop mode never lets the interval counter wrap.

Only the bench's scenarios can show the rest: the absolute timeout periods for each tick source and select code, arming, the effect of periodic clearing, the timing of the oscillator path while stopped, and the self-clearing readback of the clear bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 8;
    localparam int LIM_W  = DATA_W - 1;
    localparam int SEL_W  = 3;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_WDOG = 1'b1;

    localparam int B_WAKE  = 6;
    localparam int B_OSCEN = 5;
    localparam int B_RMODE = 4;
    localparam int B_ICLR  = 3;
    localparam int B_WCLR  = 7;

    typedef struct packed {
        logic             wake;
        logic             osc_en;
        logic             rst_mode;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{wake: 1'b0, osc_en: 1'b0, rst_mode: 1'b1, sel: '1};
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output ctrl_t             ctrl_o,
    output logic [LIM_W-1:0]  limit_o,
    output logic              ivl_clr_o,
    output logic              wd_clr_o,
    output logic              arm_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [LIM_W-1:0] limit;
        logic             clr_echo;
    } regs_t;

    regs_t q, d;
    logic  ctrl_wr, wdog_wr;

    always_comb begin
        d         = q;
        d.clr_echo = 1'b0;
        ctrl_wr   = wr_en_i && (wr_sel_i == REG_CTRL);
        wdog_wr   = wr_en_i && (wr_sel_i == REG_WDOG);
        if (ctrl_wr) begin
            d.ctrl.wake     = wr_data_i[B_WAKE];
            d.ctrl.osc_en   = wr_data_i[B_OSCEN];
            d.ctrl.rst_mode = wr_data_i[B_RMODE];
            d.ctrl.sel      = wr_data_i[SEL_W-1:0];
        end
        if (wdog_wr) begin
            d.limit    = wr_data_i[LIM_W-1:0];
            d.clr_echo = wr_data_i[B_WCLR];
        end
        ivl_clr_o = ctrl_wr && wr_data_i[B_ICLR];
        arm_o     = ctrl_wr && wr_data_i[B_ICLR] && wr_data_i[B_RMODE];
        wd_clr_o  = wdog_wr && wr_data_i[B_WCLR];
        if (rd_sel_i == REG_CTRL)
            rd_data_o = {1'b0, q.ctrl.wake, q.ctrl.osc_en, q.ctrl.rst_mode, 1'b0, q.ctrl.sel};
        else
            rd_data_o = {q.clr_echo, q.limit};
        ctrl_o  = q.ctrl;
        limit_o = q.limit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.ctrl     <= CTRL_RST;
            q.limit    <= '1;
            q.clr_echo <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
    parameter int DIV_MIN_LOG2 = 3,
    parameter int SEL_W        = 3,
    parameter int CNT_W        = 8,
    localparam int PRE_W       = DIV_MIN_LOG2 + (1 << SEL_W) - 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clr_i,
    input  logic             flag_clr_i,
    output logic             ovf_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } ivl_t;

    ivl_t q, d;
    logic [PRE_W-1:0] mask;
    logic             pre_tick;
    int               shamt;

    always_comb begin
        d        = q;
        shamt    = DIV_MIN_LOG2 + int'(sel_i);
        mask     = ~({PRE_W{1'b1}} << shamt);
        pre_tick = !stop_i && ((q.pre & mask) == mask);
        ovf_o    = pre_tick && (q.cnt == '1);
        if (!stop_i) d.pre = q.pre + PRE_W'(1);
        if (pre_tick) d.cnt = q.cnt + CNT_W'(1);
        if (clr_i) begin
            d.pre = '0;
            d.cnt = '0;
        end
        if (flag_clr_i) d.flag = 1'b0;
        if (ovf_o)      d.flag = 1'b1;
        flag_o = q.flag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/wdog_osc_tick.sv
module wdog_osc_tick #(
    parameter int SYNC_N = 2,
    parameter int DIV_W  = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic osc_i,
    input  logic en_i,
    output logic tick_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
        logic [DIV_W-1:0]  div;
    } osc_t;

    osc_t q, d;
    logic rise;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_N-2:0], osc_i};
        d.prev = q.sync[SYNC_N-1];
        rise   = q.sync[SYNC_N-1] && !q.prev;
        tick_o = en_i && rise && (q.div == '1);
        if (!en_i)     d.div = '0;
        else if (rise) d.div = q.div + DIV_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int CNT_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ivl_tick_i,
    input  logic             osc_tick_i,
    input  logic             osc_en_i,
    input  logic             rst_mode_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             wd_clr_i,
    input  logic             arm_i,
    input  logic             flag_clr_i,
    output logic             irq_o,
    output logic             rst_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             irq;
        logic             rst;
    } core_t;

    core_t            q, d;
    logic             tick, run, match;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        d     = q;
        tick  = osc_en_i ? osc_tick_i : ivl_tick_i;
        run   = !rst_mode_i || q.armed;
        nxt   = q.cnt + CNT_W'(1);
        match = 1'b0;
        if (!rst_mode_i) d.armed = 1'b0;
        if (arm_i)       d.armed = 1'b1;
        if (wd_clr_i) begin
            d.cnt = '0;
        end else if (tick && run) begin
            if (nxt == limit_i) begin
                match = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = nxt;
            end
        end
        d.rst = match && rst_mode_i;
        if (flag_clr_i)             d.irq = 1'b0;
        if (match && !rst_mode_i)   d.irq = 1'b1;
        irq_o = q.irq;
        rst_o = q.rst;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/wdog_dual_src.sv
module wdog_dual_src
    import wdog_pkg::*;
#(
    parameter int DIV_MIN_LOG2 = 3,
    parameter int IVL_W        = 8,
    parameter int SYNC_N       = 2,
    parameter int OSC_DIV_W    = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              stop_i,
    input  logic              osc_i,
    input  logic [1:0]        flag_clr_i,
    output logic              ivl_irq_o,
    output logic              wdt_irq_o,
    output logic              cpu_rst_o
);
    ctrl_t            ctrl;
    logic [LIM_W-1:0] limit;
    logic             ivl_clr, wd_clr, arm, ivl_ovf, osc_tick;

    wdog_regs u_regs (
        .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .rd_sel_i, .rd_data_o,
        .ctrl_o(ctrl), .limit_o(limit), .ivl_clr_o(ivl_clr), .wd_clr_o(wd_clr), .arm_o(arm)
    );

    wdog_interval #(.DIV_MIN_LOG2(DIV_MIN_LOG2), .SEL_W(SEL_W), .CNT_W(IVL_W)) u_ivl (
        .clk_i, .rst_ni, .stop_i, .sel_i(ctrl.sel), .clr_i(ivl_clr),
        .flag_clr_i(flag_clr_i[0]), .ovf_o(ivl_ovf), .flag_o(ivl_irq_o)
    );

    wdog_osc_tick #(.SYNC_N(SYNC_N), .DIV_W(OSC_DIV_W)) u_osc (
        .clk_i, .rst_ni, .osc_i, .en_i(ctrl.osc_en), .tick_o(osc_tick)
    );

    wdog_core #(.CNT_W(LIM_W)) u_core (
        .clk_i, .rst_ni, .ivl_tick_i(ivl_ovf), .osc_tick_i(osc_tick),
        .osc_en_i(ctrl.osc_en), .rst_mode_i(ctrl.rst_mode), .limit_i(limit),
        .wd_clr_i(wd_clr), .arm_i(arm), .flag_clr_i(flag_clr_i[1]),
        .irq_o(wdt_irq_o), .rst_o(cpu_rst_o)
    );
endmodule

// File: rtl/wdog_dual_src_sva.sv
module wdog_dual_src_sva (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       stop_i,
    input logic [1:0] flag_clr_i,
    input logic       rst_mode,
    input logic       ivl_ovf,
    input logic       ivl_irq_o,
    input logic       wdt_irq_o,
    input logic       cpu_rst_o
);
    a_r8_rst_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_rst_o |=> !cpu_rst_o);

    a_r8_rst_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_rst_o |-> $past(rst_mode));

    a_r9_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdt_irq_o && !flag_clr_i[1]) |=> wdt_irq_o);

    a_r9_irq_only_int_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_irq_o) |-> !$past(rst_mode));

    a_r2_ivl_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ivl_irq_o && !flag_clr_i[0]) |=> ivl_irq_o);

    a_r4_stop_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |-> !ivl_ovf);
endmodule

bind wdog_dual_src wdog_dual_src_sva u_sva (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .flag_clr_i(flag_clr_i),
    .rst_mode(ctrl.rst_mode), .ivl_ovf(ivl_ovf), .ivl_irq_o(ivl_irq_o),
    .wdt_irq_o(wdt_irq_o), .cpu_rst_o(cpu_rst_o)
);

// File: tb/wdog_dual_src_tb_top.sv
module wdog_dual_src_tb_top;
    localparam int TOL = 16;
    localparam int EV_RST = 0;
    localparam int EV_IRQ = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = '0, rd_data;
    logic       stop = 1'b0, osc = 1'b0;
    logic [1:0] fclr = '0;
    logic       ivl_irq, wdt_irq, cpu_rst;

    always #2 clk = ~clk;
    always #8 osc = ~osc;

    wdog_dual_src dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .stop_i(stop), .osc_i(osc), .flag_clr_i(fclr),
        .ivl_irq_o(ivl_irq), .wdt_irq_o(wdt_irq), .cpu_rst_o(cpu_rst)
    );

    int checks = 0, fails = 0, events = 0;
    longint cyc = 0;
    bit done = 0;
    typedef struct { int kind; longint at; string req; } exp_t;
    exp_t sb[$];

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data, output longint t);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        t = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk); fclr = m;
        @(negedge clk); fclr = '0;
    endtask

    task automatic wait_to(input longint target);
        while (cyc < target) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_evt(input int kind, input longint at, input string req);
        exp_t e;
        e.kind = kind; e.at = at; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: pops expected events from the scoreboard as the design produces them
    logic irq_prev = 1'b0, rst_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rst_prev && cpu_rst) check(1'b0, "R8 pulse width", 2, 1);
            if (cpu_rst || (wdt_irq && !irq_prev)) begin
                int k;
                exp_t e;
                k = cpu_rst ? EV_RST : EV_IRQ;
                events++;
                if (sb.size() == 0) begin
                    check(1'b0, "unexpected event kind", k, -1);
                end else begin
                    e = sb.pop_front();
                    check(e.kind == k, e.req, k, e.kind);
                    check((cyc >= e.at - TOL) && (cyc <= e.at + TOL), e.req, cyc, e.at);
                end
            end
        end
        irq_prev = wdt_irq;
        rst_prev = cpu_rst;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog timeout", cyc, 0);
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint t0, tw;
        int ev0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd_sel = 1'b0; #1;
        check(rd_data == 8'h17, "R1 control reset", rd_data, 8'h17);
        rd_sel = 1'b1; #1;
        check(rd_data == 8'h7F, "R1 watchdog reset", rd_data, 8'h7F);
        check({ivl_irq, wdt_irq, cpu_rst} == 3'b000, "R1 outputs low", {ivl_irq, wdt_irq, cpu_rst}, 0);

        // R10 unarmed reset mode: limit 2, select 0, no clear -> no reset
        wr(1'b1, 8'h02, tw);
        wr(1'b0, 8'h10, t0);
        wait_to(t0 + 7000);
        check(events == 0, "R10 unarmed no reset", events, 0);
        check(ivl_irq == 1'b1, "R2 interval flag set", ivl_irq, 1);
        pulse_clr(2'b01);
        check(ivl_irq == 1'b0, "R2 interval flag cleared", ivl_irq, 0);

        // R8/R5/R10 arm: clear with mode 1 -> reset every 2 wraps of 2048 cycles
        wr(1'b0, 8'h18, t0);
        expect_evt(EV_RST, t0 + 4096, "R8 first reset");
        expect_evt(EV_RST, t0 + 8192, "R5 restart after match");
        wait_to(t0 + 8192 + 20);
        check(events == 2, "R8 reset count", events, 2);

        // R7 periodic clear keeps the watchdog quiet; clear bit self-clears
        wr(1'b0, 8'h18, t0);
        wr(1'b1, 8'h82, tw);
        rd_sel = 1'b1; #1;
        check(rd_data == 8'h82, "R7 clear bit reads 1", rd_data, 8'h82);
        @(posedge clk); #1;
        check(rd_data == 8'h02, "R7 clear bit returns 0", rd_data, 8'h02);
        ev0 = events;
        for (int i = 0; i < 5; i++) begin
            wait_to(tw + 2000);
            wr(1'b1, 8'h82, tw);
        end
        check(events == ev0, "R7 no event while cleared", events, ev0);

        // R9 interrupt mode, limit 3
        wr(1'b1, 8'h83, tw);
        wr(1'b0, 8'h08, t0);
        rd_sel = 1'b0; #1;
        check(rd_data == 8'h00, "R3 clear bit reads 0", rd_data, 8'h00);
        expect_evt(EV_IRQ, t0 + 6144, "R9 irq timing");
        wait_to(t0 + 6144 + 200);
        check(wdt_irq == 1'b1, "R9 irq sticky", wdt_irq, 1);
        pulse_clr(2'b10);
        check(wdt_irq == 1'b0, "R9 irq cleared", wdt_irq, 0);

        // R6/R4 oscillator source under stop mode
        @(negedge clk); stop = 1'b1;
        pulse_clr(2'b01);
        wr(1'b0, 8'h20, t0);
        wr(1'b1, 8'h82, tw);
        expect_evt(EV_IRQ, t0 + 2048, "R6 oscillator irq in stop");
        wait_to(t0 + 3000);
        check(ivl_irq == 1'b0, "R4 stop freezes interval", ivl_irq, 0);
        check(wdt_irq == 1'b1, "R6 irq during stop", wdt_irq, 1);
        pulse_clr(2'b10);
        @(negedge clk); stop = 1'b0;

        // R2/R3 select 1 with interval clear: wrap at 4096 cycles
        wr(1'b1, 8'hFF, tw);
        wr(1'b0, 8'h09, t0);
        pulse_clr(2'b01);
        wait_to(t0 + 4096 - TOL);
        check(ivl_irq == 1'b0, "R2 select 1 before wrap", ivl_irq, 0);
        wait_to(t0 + 4096 + TOL);
        check(ivl_irq == 1'b1, "R3 select 1 wrap after clear", ivl_irq, 1);

        repeat (20) @(negedge clk);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule